// File: doc/BRIEF.md
# Cache Data-SRAM Diagnostic Access Steering

This block steers each CPU bus cycle between the secondary-cache data SRAM and main memory. It has two ways of working. In normal operation the hit decision comes from the tag comparison, and the usual cache bookkeeping requests pass through: castout, line fill, tag write and DRAM write. In diagnostic mode the tag is not used. The CPU address is compared against a programmable test window instead. A hit inside the window goes straight to the data SRAM, so diagnostic firmware can write and read the array and can size it. All bookkeeping is suppressed in this mode, and writes inside the window never reach DRAM.

Each cycle runs through a three-state machine with the states IDLE, DECODE and ACCESS. The transitions are:
- IDLE→DECODE when a start strobe is seen. At that edge the address and every configuration and normal-path input are captured.
- DECODE→ACCESS unconditionally. In this step the window compare is registered.
- ACCESS→IDLE unconditionally. During ACCESS the chip selects, the cache address bit, the DRAM hit indication and the bookkeeping requests are driven for exactly one cycle.

The bank mapping supports single-bank and dual-bank SRAM. It also selects the cache address bit CA2 according to the cache-size code.

Top module: `sram_diag_steer`

## Requirements
- R1: Diagnostic mode applies to a cycle only if `cfg_test_en`=1 and `cfg_cache_en`, `cfg_cache_init` and `cfg_dir_freeze` are all 0 when the cycle starts. In any other case the cycle is handled in normal mode.
- R2: In diagnostic mode, `hit_to_dram` is 1 exactly when `bus_addr` and `cfg_win_base` agree on all bits from 16+`cfg_size` upward, and `tag_hit` has no effect. The `cfg_size` codes are 0=64K, 1=128K, 2=256K, 3=512K and 4=1M; codes above 4 act as 4.
- R3: In diagnostic mode, `castout_req`, `fill_req` and `tag_wr_req` stay 0.
- R4: In diagnostic mode, `dram_wr_req` is 1 only for a write outside the window. A write inside the window never raises it.
- R5: In diagnostic mode, an access outside the window selects no SRAM bank.
- R6: In normal mode, `hit_to_dram` equals `tag_hit`, and the four bookkeeping requests equal the `norm_*` inputs captured at the start.
- R7: For a hit in dual-bank mode (`cfg_dual_bank`=1), `sram_cs0` is asserted when address bit 2 is 0 and `sram_cs1` when it is 1, and `sram_ca2` = address bit 16+size. In single-bank mode only `sram_cs0` is ever used, and `sram_ca2` = address bit 2.
- R8: `sram_rd_drive` is 1 only for a read that selected a bank. In single-bank mode, reads of bytes 4–7 and 12–15 of a line (address bit 2 = 1) leave the bus undriven.
- R9: `cpu_ken_out` always equals `cpu_ken_in`, whatever the mode.
- R10: Outputs are valid together with `cycle_done` for exactly one cycle, two clocks after the edge that samples `bus_start`. All steering outputs are 0 at every other time. A `bus_start` seen while not in IDLE is ignored.
- R11: Changing any input after the start edge does not alter the result of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start of a CPU bus cycle |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_write | input | 1 | 1 = write cycle |
| cpu_ken_in | input | 1 | Cacheability from the address decoder |
| tag_hit | input | 1 | Tag comparison result |
| norm_castout | input | 1 | Normal-path castout request |
| norm_fill | input | 1 | Normal-path line-fill request |
| norm_tag_wr | input | 1 | Normal-path tag-write request |
| norm_dram_wr | input | 1 | Normal-path DRAM write request |
| cfg_test_en | input | 1 | Diagnostic mode request |
| cfg_cache_en | input | 1 | Cache enable control |
| cfg_cache_init | input | 1 | Cache initialise control |
| cfg_dir_freeze | input | 1 | Directory freeze control |
| cfg_dual_bank | input | 1 | 1 = two SRAM banks fitted |
| cfg_size | input | SZ_W | Cache-size code |
| cfg_win_base | input | ADDR_W | Test window base address |
| cpu_ken_out | output | 1 | Cacheability returned to CPU |
| cycle_done | output | 1 | Marks the ACCESS cycle |
| hit_to_dram | output | 1 | Hit indication to DRAM controller |
| sram_cs0 | output | 1 | Bank 0 chip select |
| sram_cs1 | output | 1 | Bank 1 chip select |
| sram_ca2 | output | 1 | Cache address bit CA2 |
| sram_rd_drive | output | 1 | SRAM drives the data bus |
| castout_req | output | 1 | Castout request |
| fill_req | output | 1 | Line-fill request |
| tag_wr_req | output | 1 | Tag write request |
| dram_wr_req | output | 1 | DRAM write request |

## Verification
Some properties are checked on every cycle:
- the outputs stay quiet outside ACCESS;
- `cycle_done` lasts a single cycle;
- the two chip selects are never active together;
- bookkeeping is silent in diagnostic mode;
- no DRAM write follows a window hit;
- the single-bank upper lanes are never driven.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model. This covers:
- the window compare at each size code;
- the choice of the CA2 source bit;
- the mode gating by the three controls;
- the pass-through of normal requests;
- the capture of inputs at the start edge;
- the ignoring of a start strobe while busy.

// File: rtl/sram_diag_pkg.sv
package sram_diag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_ACCESS = 2'd2
    } steer_state_t;

    localparam int MIN_WIN_LOG2 = 16;
    localparam int MAX_SIZE_CODE = 4;
    localparam int LANE_BIT = 2;
endpackage

// File: rtl/sram_win_decode.sv
module sram_win_decode
    import sram_diag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size,
    output logic              in_window
);
    logic [ADDR_W-1:0] keep_mask;
    int                shift;

    always_comb begin
        shift = MIN_WIN_LOG2 + ((int'(size) > MAX_SIZE_CODE) ? MAX_SIZE_CODE : int'(size));
        keep_mask = {ADDR_W{1'b1}} << shift;
        in_window = (((addr ^ base) & keep_mask) == '0);
    end
endmodule

// File: rtl/sram_bank_map.sv
module sram_bank_map
    import sram_diag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              dual,
    output logic              upper_lane,
    output logic              lane_fitted,
    output logic              ca2
);
    int ca_src;

    always_comb begin
        ca_src      = MIN_WIN_LOG2 + ((int'(size) > MAX_SIZE_CODE) ? MAX_SIZE_CODE : int'(size));
        upper_lane  = addr[LANE_BIT];
        lane_fitted = dual | ~addr[LANE_BIT];
        ca2         = dual ? addr[ca_src] : addr[LANE_BIT];
    end
endmodule

// File: rtl/sram_diag_steer.sv
module sram_diag_steer
    import sram_diag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              cpu_ken_in,
    input  logic              tag_hit,
    input  logic              norm_castout,
    input  logic              norm_fill,
    input  logic              norm_tag_wr,
    input  logic              norm_dram_wr,
    input  logic              cfg_test_en,
    input  logic              cfg_cache_en,
    input  logic              cfg_cache_init,
    input  logic              cfg_dir_freeze,
    input  logic              cfg_dual_bank,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [ADDR_W-1:0] cfg_win_base,
    output logic              cpu_ken_out,
    output logic              cycle_done,
    output logic              hit_to_dram,
    output logic              sram_cs0,
    output logic              sram_cs1,
    output logic              sram_ca2,
    output logic              sram_rd_drive,
    output logic              castout_req,
    output logic              fill_req,
    output logic              tag_wr_req,
    output logic              dram_wr_req
);
    steer_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q, base_q;
    logic [SZ_W-1:0]   size_q;
    logic              write_q, tag_q, dual_q, test_q;
    logic              nco_q, nfi_q, ntw_q, ndw_q;
    logic              win_hit_q, win_hit_c;
    logic              upper_lane, lane_fitted, ca2_c;
    logic              hit_c, cs_en;

    assign cpu_ken_out = cpu_ken_in;

    sram_win_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_win (
        .addr(addr_q), .base(base_q), .size(size_q), .in_window(win_hit_c)
    );

    sram_bank_map #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_bank (
        .addr(addr_q), .size(size_q), .dual(dual_q),
        .upper_lane(upper_lane), .lane_fitted(lane_fitted), .ca2(ca2_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bus_start) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            base_q    <= '0;
            size_q    <= '0;
            write_q   <= 1'b0;
            tag_q     <= 1'b0;
            dual_q    <= 1'b0;
            test_q    <= 1'b0;
            nco_q     <= 1'b0;
            nfi_q     <= 1'b0;
            ntw_q     <= 1'b0;
            ndw_q     <= 1'b0;
            win_hit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && bus_start) begin
                addr_q  <= bus_addr;
                base_q  <= cfg_win_base;
                size_q  <= cfg_size;
                write_q <= bus_write;
                tag_q   <= tag_hit;
                dual_q  <= cfg_dual_bank;
                test_q  <= cfg_test_en & ~cfg_cache_en & ~cfg_cache_init & ~cfg_dir_freeze;
                nco_q   <= norm_castout;
                nfi_q   <= norm_fill;
                ntw_q   <= norm_tag_wr;
                ndw_q   <= norm_dram_wr;
            end
            if (state_q == ST_DECODE) win_hit_q <= win_hit_c;
        end
    end

    always_comb begin
        cycle_done    = 1'b0;
        hit_to_dram   = 1'b0;
        sram_cs0      = 1'b0;
        sram_cs1      = 1'b0;
        sram_ca2      = 1'b0;
        sram_rd_drive = 1'b0;
        castout_req   = 1'b0;
        fill_req      = 1'b0;
        tag_wr_req    = 1'b0;
        dram_wr_req   = 1'b0;
        hit_c         = test_q ? win_hit_q : tag_q;
        cs_en         = hit_c & lane_fitted;
        unique case (state_q)
            ST_ACCESS: begin
                cycle_done    = 1'b1;
                hit_to_dram   = hit_c;
                sram_cs0      = cs_en & ~upper_lane;
                sram_cs1      = cs_en & upper_lane;
                sram_ca2      = ca2_c;
                sram_rd_drive = cs_en & ~write_q;
                castout_req   = ~test_q & nco_q;
                fill_req      = ~test_q & nfi_q;
                tag_wr_req    = ~test_q & ntw_q;
                dram_wr_req   = test_q ? (write_q & ~win_hit_q) : ndw_q;
            end
            default: ;
        endcase
    end

    assert_quiet_outside_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACCESS) |-> !(cycle_done | hit_to_dram | sram_cs0 | sram_cs1 |
                                     castout_req | fill_req | tag_wr_req | dram_wr_req));
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);
    assert_no_bookkeeping_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && test_q) |-> !(castout_req | fill_req | tag_wr_req));
    assert_window_no_dram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && test_q && win_hit_q) |-> !dram_wr_req);
    assert_bank_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_cs0, sram_cs1}));
    assert_upper_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !dual_q && addr_q[LANE_BIT]) |-> !(sram_rd_drive | sram_cs1));
endmodule

// File: tb/sim_sram_diag_steer.sv
module sim_sram_diag_steer;
    localparam int AW = 32;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_start = 0, bus_write = 0, cpu_ken_in = 0, tag_hit = 0;
    logic norm_castout = 0, norm_fill = 0, norm_tag_wr = 0, norm_dram_wr = 0;
    logic cfg_test_en = 0, cfg_cache_en = 0, cfg_cache_init = 0, cfg_dir_freeze = 0, cfg_dual_bank = 0;
    logic [SW-1:0] cfg_size = '0;
    logic [AW-1:0] bus_addr = '0, cfg_win_base = '0;
    logic cpu_ken_out, cycle_done, hit_to_dram, sram_cs0, sram_cs1, sram_ca2, sram_rd_drive;
    logic castout_req, fill_req, tag_wr_req, dram_wr_req;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    sram_diag_steer #(.ADDR_W(AW), .SZ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr), .bus_write(bus_write),
        .cpu_ken_in(cpu_ken_in), .tag_hit(tag_hit), .norm_castout(norm_castout), .norm_fill(norm_fill),
        .norm_tag_wr(norm_tag_wr), .norm_dram_wr(norm_dram_wr), .cfg_test_en(cfg_test_en),
        .cfg_cache_en(cfg_cache_en), .cfg_cache_init(cfg_cache_init), .cfg_dir_freeze(cfg_dir_freeze),
        .cfg_dual_bank(cfg_dual_bank), .cfg_size(cfg_size), .cfg_win_base(cfg_win_base),
        .cpu_ken_out(cpu_ken_out), .cycle_done(cycle_done), .hit_to_dram(hit_to_dram),
        .sram_cs0(sram_cs0), .sram_cs1(sram_cs1), .sram_ca2(sram_ca2), .sram_rd_drive(sram_rd_drive),
        .castout_req(castout_req), .fill_req(fill_req), .tag_wr_req(tag_wr_req), .dram_wr_req(dram_wr_req)
    );

    // {done, hit, cs0, cs1, ca2, rd, castout, fill, tagwr, dramwr}
    function automatic logic [9:0] model();
        logic test, win, hit, dual, up, fitted, cs, ca2;
        int sz;
        sz = (int'(cfg_size) > 4) ? 4 : int'(cfg_size);
        test = cfg_test_en && !cfg_cache_en && !cfg_cache_init && !cfg_dir_freeze;
        win = ((bus_addr >> (16 + sz)) == (cfg_win_base >> (16 + sz)));
        hit = test ? win : tag_hit;
        dual = cfg_dual_bank;
        up = bus_addr[2];
        fitted = dual || !up;
        cs = hit && fitted;
        ca2 = dual ? bus_addr[16 + sz] : bus_addr[2];
        return {1'b1, hit, cs && !up, cs && up, ca2, cs && !bus_write,
                !test && norm_castout, !test && norm_fill, !test && norm_tag_wr,
                test ? (bus_write && !win) : norm_dram_wr};
    endfunction

    function automatic logic [9:0] observed();
        return {cycle_done, hit_to_dram, sram_cs0, sram_cs1, sram_ca2, sram_rd_drive,
                castout_req, fill_req, tag_wr_req, dram_wr_req};
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic scramble();
        bus_addr = $urandom; cfg_win_base = $urandom; cfg_size = 3'($urandom);
        bus_write = 1'($urandom); tag_hit = 1'($urandom); cfg_test_en = 1'($urandom);
        cfg_dual_bank = 1'($urandom); norm_castout = 1'($urandom); norm_fill = 1'($urandom);
        norm_tag_wr = 1'($urandom); norm_dram_wr = 1'($urandom); cfg_cache_en = 1'($urandom);
    endtask

    // Start a cycle with current inputs, disturb inputs afterwards (R11), check ACCESS (R10).
    task automatic run_txn(input string req, input bit poke_start);
        logic [9:0] exp;
        @(negedge clk);
        exp = model();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = poke_start;
        scramble();
        check({observed()}, 10'b0, "R10 decode quiet");
        @(negedge clk);
        bus_start = 1'b0;
        check(observed(), exp, req);
        @(negedge clk);
        check(observed(), 10'b0, "R10 busy start ignored");
    endtask

    task automatic set_mode(input bit t, input bit ce, input bit ci, input bit fz);
        cfg_test_en = t; cfg_cache_en = ce; cfg_cache_init = ci; cfg_dir_freeze = fz;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check(observed(), 10'b0, "R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(observed(), 10'b0, "R10 idle after reset");

        // R9 ken pass-through
        cpu_ken_in = 1'b1; set_mode(1, 0, 0, 0); #1;
        check({9'b0, cpu_ken_out}, 10'd1, "R9 ken high in test mode");
        cpu_ken_in = 1'b0; #1;
        check({9'b0, cpu_ken_out}, 10'd0, "R9 ken low");

        // R2/R4 write inside window, tag miss ignored
        cfg_size = 3'd3; cfg_win_base = 32'h0008_0000; bus_addr = 32'h0008_1230;
        bus_write = 1; tag_hit = 0; cfg_dual_bank = 1;
        norm_castout = 1; norm_fill = 1; norm_tag_wr = 1; norm_dram_wr = 1;
        run_txn("R2 R3 R4 window write", 1'b0);
        // R5 outside window write goes to DRAM
        set_mode(1, 0, 0, 0); cfg_size = 3'd3; cfg_win_base = 32'h0008_0000;
        bus_addr = 32'h0010_0000; bus_write = 1; tag_hit = 1; cfg_dual_bank = 1;
        run_txn("R4 R5 outside window", 1'b0);
        // R8 single bank upper lanes float
        set_mode(1, 0, 0, 0); cfg_size = 3'd2; cfg_win_base = 32'h0004_0000;
        bus_addr = 32'h0004_000C; bus_write = 0; cfg_dual_bank = 0;
        run_txn("R8 single bank bytes 12-15", 1'b0);
        // R7 ca2 source for each size, dual bank
        for (int s = 0; s < 6; s++) begin
            set_mode(1, 0, 0, 0); cfg_size = 3'(s); cfg_win_base = 32'h0010_0000;
            bus_addr = 32'h0010_0004 | (32'h1 << (16 + ((s > 4) ? 4 : s)));
            cfg_dual_bank = 1; bus_write = 0;
            run_txn("R7 ca2 source bit", 1'b0);
        end
        // R1 each gating control forces normal mode
        for (int g = 0; g < 3; g++) begin
            set_mode(1, g == 0, g == 1, g == 2);
            cfg_size = 3'd0; cfg_win_base = 32'h0; bus_addr = 32'h0000_0100; tag_hit = 0;
            bus_write = 1; norm_castout = 1; norm_fill = 0; norm_tag_wr = 1; norm_dram_wr = 0;
            run_txn("R1 R6 gated to normal", 1'b0);
        end
        // R10 start held during busy
        set_mode(0, 1, 0, 0); tag_hit = 1; bus_addr = 32'h40;
        run_txn("R10 R6 start while busy", 1'b1);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            scramble();
            cfg_cache_init = ($urandom % 8) == 0;
            cfg_dir_freeze = ($urandom % 8) == 0;
            cfg_cache_en = ($urandom % 4) == 0;
            cfg_size = 3'($urandom % 5);
            if ($urandom % 2) bus_addr = cfg_win_base ^ ($urandom & 32'h0000_FFFF);
            run_txn("R2 R6 R7 R11 random", 1'($urandom % 6 == 0));
        end
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule